// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is the programming port of a synthesizer-style control path. An external host drives three wires: a serial clock, a serial data line and a latch-enable strobe. Data bits enter an 18-bit shift register on each rising edge of the serial clock, most significant bit first. When latch enable rises, the two bits shifted in last act as an address that selects one of four holding slots, and the remaining 16 bits are copied into that slot.

Every slot drives its 16-bit payload to downstream logic. It also raises a one-cycle "written" strobe. Each slot has a second, active copy of the payload that feeds the slot's counter. The active copy takes the holding value only when that counter reports its terminal count. A new setting therefore reaches the counter at a wrap boundary and never in the middle of a count. The three serial pins are asynchronous. They pass through a two-stage synchronizer into the system clock domain, and edges are found on the synchronized levels.

Top module: `serial_latch_loader`

## Requirements
- R1: On each rising edge of the serial clock the data bit enters the shift register at bit 0, and the older bits move one place toward bit 17. The word therefore arrives most significant bit first. Extra or missing clocks are not flagged, and the last 18 bits shifted in are the ones used.
- R2: Word bits [1:0] (the last two bits shifted in) give the slot number as an unsigned binary value from 0 to 3. Word bits [17:2] form the payload. Slot k occupies hold_o[16k+15:16k] and act_o[16k+15:16k].
- R3: On a rising edge of latch enable the addressed slot's holding value becomes the payload. A latch enable held high, or a falling edge, writes nothing further.
- R4: A slot's holding value changes only when that slot is written. A write to one slot leaves the other three unchanged.
- R5: A write raises upd_o[k] for exactly one system clock cycle, in the same cycle that hold_o first shows the new payload. At most one bit of upd_o is high at any time.
- R6: When tc_i[k] is high on a system clock edge, the active value of slot k takes that slot's holding value, as it was before any write made at the same edge. In every other cycle the active value holds.
- R7: While rst_n is low, all holding values, all active values and upd_o are zero.
- R8: A change on the serial data line without a serial clock rising edge alters no state. A pin change takes effect at the third system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Latch enable, asynchronous |
| tc_i | input | 4 | Per-slot terminal-count pulse from the counters |
| hold_o | output | 64 | Four holding payloads, slot 0 in the low 16 bits |
| act_o | output | 64 | Four active payloads, slot 0 in the low 16 bits |
| upd_o | output | 4 | One-cycle per-slot written strobe |

## Verification
The bench builds the block with its default 18-bit word and 2-bit address. At these values every one of the four slots is reachable, and each can be written with a distinct payload that the scoreboard follows. With the word fixed at 18 bits, an overrun of four extra clocks can be sent to show that only the final 18 bits count. A latch enable held high for many cycles checks that only the rising edge writes. Terminal-count pulses are given to one slot and then to all four, so the bench can tell the active copies apart from the holding ones.

// File: rtl/sll_pkg.sv
package sll_pkg;
  localparam int unsigned DEF_WORD_W = 18;
  localparam int unsigned DEF_ADDR_W = 2;
  localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/sll_pin_sync.sv
module sll_pin_sync #(
  parameter int unsigned STAGES = sll_pkg::DEF_SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], pin_i};
  end

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/sll_shifter.sv
module sll_shifter #(
  parameter int unsigned WORD_W = sll_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_o <= '0;
    else if (step_i) word_o <= push_bit(word_o, bit_i);
  end
endmodule

// File: rtl/sll_slot_bank.sv
module sll_slot_bank #(
  parameter int unsigned ADDR_W = sll_pkg::DEF_ADDR_W,
  parameter int unsigned PAY_W  = sll_pkg::DEF_WORD_W - sll_pkg::DEF_ADDR_W,
  localparam int unsigned SLOTS = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [PAY_W-1:0]       pay_i,
  input  logic [SLOTS-1:0]       tc_i,
  output logic [SLOTS*PAY_W-1:0] hold_o,
  output logic [SLOTS*PAY_W-1:0] act_o,
  output logic [SLOTS-1:0]       upd_o
);
  function automatic logic [SLOTS-1:0] decode_slot(input logic [ADDR_W-1:0] a);
    logic [SLOTS-1:0] r;
    r = '0;
    r[a] = 1'b1;
    return r;
  endfunction

  logic [SLOTS-1:0] sel;
  assign sel = wr_i ? decode_slot(addr_i) : '0;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [PAY_W-1:0] hold_q, act_q;
    logic             upd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        act_q  <= '0;
        upd_q  <= 1'b0;
      end else begin
        upd_q <= sel[k];
        if (sel[k])  hold_q <= pay_i;
        if (tc_i[k]) act_q  <= hold_q;
      end
    end

    assign hold_o[k*PAY_W +: PAY_W] = hold_q;
    assign act_o[k*PAY_W +: PAY_W]  = act_q;
    assign upd_o[k]                 = upd_q;
  end
endmodule

// File: rtl/serial_latch_loader.sv
module serial_latch_loader #(
  parameter int unsigned WORD_W = sll_pkg::DEF_WORD_W,
  parameter int unsigned ADDR_W = sll_pkg::DEF_ADDR_W,
  parameter int unsigned SYNC_N = sll_pkg::DEF_SYNC_N,
  localparam int unsigned PAY_W = WORD_W - ADDR_W,
  localparam int unsigned SLOTS = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_le_i,
  input  logic [SLOTS-1:0]       tc_i,
  output logic [SLOTS*PAY_W-1:0] hold_o,
  output logic [SLOTS*PAY_W-1:0] act_o,
  output logic [SLOTS-1:0]       upd_o
);
  logic sclk_lvl, sdat_lvl, le_lvl;
  logic sclk_prev, le_prev;
  logic sclk_rise, le_rise;
  logic [WORD_W-1:0] shift_word;

  sll_pin_sync #(.STAGES(SYNC_N)) u_sync_clk (.clk(clk), .rst_n(rst_n), .pin_i(ser_clk_i), .lvl_o(sclk_lvl));
  sll_pin_sync #(.STAGES(SYNC_N)) u_sync_dat (.clk(clk), .rst_n(rst_n), .pin_i(ser_dat_i), .lvl_o(sdat_lvl));
  sll_pin_sync #(.STAGES(SYNC_N)) u_sync_le  (.clk(clk), .rst_n(rst_n), .pin_i(ser_le_i),  .lvl_o(le_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
    end else begin
      sclk_prev <= sclk_lvl;
      le_prev   <= le_lvl;
    end
  end

  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign le_rise   = le_lvl & ~le_prev;

  sll_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .step_i(sclk_rise), .bit_i(sdat_lvl), .word_o(shift_word)
  );

  sll_slot_bank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_i(le_rise),
    .addr_i(shift_word[ADDR_W-1:0]), .pay_i(shift_word[WORD_W-1:ADDR_W]),
    .tc_i(tc_i), .hold_o(hold_o), .act_o(act_o), .upd_o(upd_o)
  );
endmodule

// File: rtl/sll_checker.sv
module sll_checker #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned PAY_W  = 16,
  localparam int unsigned SLOTS = 1 << ADDR_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   le_rise,
  input logic [ADDR_W-1:0]      sw_addr,
  input logic [SLOTS-1:0]       tc_i,
  input logic [SLOTS*PAY_W-1:0] hold_o,
  input logic [SLOTS*PAY_W-1:0] act_o,
  input logic [SLOTS-1:0]       upd_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (hold_o == '0 && act_o == '0 && upd_o == '0)); // R7
  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd_o)); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (upd_o == '0) |-> $stable(hold_o)); // R4
  AST_LE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> (upd_o == (SLOTS'(1) << $past(sw_addr)))); // R3

  for (genvar k = 0; k < SLOTS; k++) begin : g_act
    AST_ACT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      tc_i[k] |=> (act_o[k*PAY_W +: PAY_W] == $past(hold_o[k*PAY_W +: PAY_W]))); // R6
    AST_ACT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !tc_i[k] |=> $stable(act_o[k*PAY_W +: PAY_W])); // R6
  end
endmodule

bind serial_latch_loader sll_checker #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .sw_addr(shift_word[ADDR_W-1:0]),
  .tc_i(tc_i), .hold_o(hold_o), .act_o(act_o), .upd_o(upd_o)
);

// File: tb/serial_latch_loader_bench.sv
module serial_latch_loader_bench;
  localparam int PW = 16;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, sle = 1'b0;
  logic [NS-1:0] tc = '0;
  logic [NS*PW-1:0] hold, act;
  logic [NS-1:0] upd;

  int checks = 0;
  int fails = 0;
  logic [PW-1:0] shadow [NS];
  logic [17:0] q_word [$];
  logic [17:0] last_word = '0;

  always #5 clk = ~clk;

  serial_latch_loader u_serial_latch_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdi), .ser_le_i(sle),
    .tc_i(tc), .hold_o(hold), .act_o(act), .upd_o(upd)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sck = 1'b0; idle(3);
    sck = 1'b1; idle(3);
    sck = 1'b0;
    last_word = {last_word[16:0], b};
  endtask

  task automatic send_word(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) send_bit(w[i]);
  endtask

  // Scoreboard driver: a latch-enable pulse pushes the item the design must produce
  task automatic pulse_le(input int high_cycles);
    q_word.push_back(last_word);
    sle = 1'b1; idle(high_cycles);
    sle = 1'b0; idle(4);
  endtask

  task automatic write_slot(input logic [1:0] a, input logic [15:0] p);
    send_word({p, a});
    pulse_le(3);
  endtask

  // Monitor: pops one expected item for every strobe
  always @(negedge clk) begin
    if (rst_n && upd != '0) begin
      if (q_word.size() == 0) begin
        check("R3 unexpected strobe", 64'(upd), 64'h0);
      end else begin
        logic [17:0] w;
        w = q_word.pop_front();
        shadow[w[1:0]] = w[17:2];
        check("R5 strobe slot", 64'(upd), 64'(4'b0001 << w[1:0]));
        for (int k = 0; k < NS; k++)
          check("R2/R4 hold slot", 64'(hold[k*PW +: PW]), 64'(shadow[k]));
      end
    end
  end

  task automatic pulse_tc(input logic [NS-1:0] m);
    tc = m; idle(1); tc = '0;
  endtask

  initial begin
    for (int k = 0; k < NS; k++) shadow[k] = '0;
    idle(3);
    check("R7 reset hold", 64'(hold), 64'h0);
    check("R7 reset act", 64'(act), 64'h0);
    check("R7 reset upd", 64'(upd), 64'h0);
    rst_n = 1'b1; idle(3);

    write_slot(2'd0, 16'hA51C);
    write_slot(2'd1, 16'h0F0F);
    write_slot(2'd2, 16'hFFFF);
    write_slot(2'd3, 16'h8001);
    check("R1 all slots written", 64'(q_word.size()), 64'h0);
    check("R6 act idle without tc", 64'(act), 64'h0);

    pulse_tc(4'b0100);
    idle(1);
    check("R6 act slot2 taken", 64'(act[2*PW +: PW]), 64'hFFFF);
    check("R6 act slot0 kept", 64'(act[0 +: PW]), 64'h0);
    pulse_tc(4'b1111);
    idle(1);
    check("R6 act all taken", 64'(act), 64'(hold));

    // R1: overrun with four leading junk bits; last 18 bits win
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    write_slot(2'd1, 16'h1234);
    check("R1 overrun slot1", 64'(hold[1*PW +: PW]), 64'h1234);
    check("R4 act unchanged by write", 64'(act[1*PW +: PW]), 64'h0F0F);

    // R8: data toggles without clock edges, then latch again
    for (int i = 0; i < 6; i++) begin sdi = ~sdi; idle(3); end
    pulse_le(3);
    check("R8 data wiggle ignored", 64'(hold[1*PW +: PW]), 64'h1234);

    // R3: long latch-enable high yields one write only
    send_word({16'h5AA5, 2'd3});
    pulse_le(20);
    idle(4);
    check("R3 long le single write", 64'(hold[3*PW +: PW]), 64'h5AA5);
    check("R3 queue drained", 64'(q_word.size()), 64'h0);

    rst_n = 1'b0; idle(2);
    check("R7 mid reset hold", 64'(hold), 64'h0);
    check("R7 mid reset act", 64'(act), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule